// File: doc/BRIEF.md
# Segmented Gate-Drive Profile Sequencer

This block plays a programmed drive-strength profile onto the two transistor banks of a digitally controlled gate driver. Every clock period (40 ns at the intended rate) is one time segment, and in each segment the block presents a 6-bit count of how many parallel driver transistors are switched on. The count goes to the pull-up bank for a turn-on edge or to the pull-down bank for a turn-off edge. The bank that is not selected always receives zero.

A single-cycle start pulse launches a profile. In free-form mode the block emits eight programmed segment counts back to back and then settles on a separately programmed final level. In three-phase mode it emits a base level for a first duration, an intermediate level for a second duration, and then returns to the base level and stays there. Durations are cycle counts. All settings are captured at the accepted start, so software or an optimiser loop can prepare the next profile while the current one plays. The output level is held until the next accepted start.

Top module: `gdrv_profile_seq`

## Requirements
- R1: After reset, `up_code` and `down_code` are 0, and `busy` and `done` are low.
- R2: With `three_phase`=0, a start sampled high at a clock edge while `busy` is low makes segment j (bits 6j+5..6j of `seg_levels`, j=0..7) the output count in the (j+1)-th cycle after that edge, one segment per cycle.
- R3: With `three_phase`=0, `end_level` becomes the output count in the 9th cycle after the start edge and stays there until the next accepted start.
- R4: With `three_phase`=1, the output count is `base_level` for `first_len` cycles starting in the 1st cycle after the start edge, then `mid_level` for `second_len` cycles, then `base_level` again until the next accepted start.
- R5: A `first_len` or `second_len` of 0 is treated as 1 cycle.
- R6: With `drive_up`=1 the count appears on `up_code` and `down_code` is 0; with `drive_up`=0 it appears on `down_code` and `up_code` is 0, for every cycle of the profile and the hold that follows.
- R7: `busy` is high in every segment cycle of a profile and low from the first cycle that shows the final held level.
- R8: `done` is high for exactly one cycle, the first cycle that shows the final held level.
- R9: A start pulse while `busy` is high is ignored; the running profile continues unchanged.
- R10: Mode, bank, levels and durations are sampled at the accepted start; changes to them while `busy` is high have no effect on the running profile or its final level.
- R11: A start sampled in the cycle where `done` is high is accepted, so profiles can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Segment clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch pulse for a profile |
| three_phase | input | 1 | 1 selects the three-phase profile, 0 the free-form eight-segment profile |
| drive_up | input | 1 | 1 steers the count to the pull-up bank (turn-on), 0 to the pull-down bank (turn-off) |
| seg_levels | input | 48 | Eight free-form segment counts, segment j in bits 6j+5..6j |
| end_level | input | 6 | Final held count in free-form mode |
| base_level | input | 6 | First and final count in three-phase mode |
| mid_level | input | 6 | Intermediate count in three-phase mode |
| first_len | input | 8 | Cycles spent on the base level in three-phase mode |
| second_len | input | 8 | Cycles spent on the intermediate level in three-phase mode |
| up_code | output | 6 | Active transistor count for the pull-up bank |
| down_code | output | 6 | Active transistor count for the pull-down bank |
| busy | output | 1 | High while a profile is playing |
| done | output | 1 | One-cycle pulse when the final level is reached |

## Verification
Free-form profiles are played with counts that alternate between the extremes 0 and 63 and with adjacent mid-scale values. A mis-ordered, skipped or repeated segment therefore shows up as a wrong count in a specific cycle. Three-phase profiles use short asymmetric durations of 1 and 2 cycles, a 4-and-4 profile with an intermediate level of 0, and zero durations. These separate an off-by-one in either phase counter from a swapped phase order. Both banks are driven in turn so that a wrong steering or a leaking count on the idle bank is caught. A run that changes every setting and pulses start mid-profile shows that the captured settings are used, and a start issued on the done cycle shows that back-to-back profiles are accepted without a lost cycle.

// File: rtl/gdrv_pkg.sv
// Package: shared types for the gate-drive profile sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package gdrv_pkg;

    // Sequencer phase: idle/holding, free-form segments, three-phase first and middle legs
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEG  = 2'd1,
        ST_PH1  = 2'd2,
        ST_PH2  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/gdrv_cfg_hold.sv
// Module: gdrv_cfg_hold
// Captures the profile settings when a start is accepted and presents the
// settings the sequencer must use. In the accepting cycle the raw inputs are
// passed straight through, so the first segment needs no extra cycle.
// Assumes: accept is high only when the sequencer is idle.
module gdrv_cfg_hold #(
    parameter int NSEG = 8,
    parameter int LW   = 6,
    parameter int DW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              busy,
    input  logic              raw_three,
    input  logic              raw_up,
    input  logic [NSEG*LW-1:0] raw_segs,
    input  logic [LW-1:0]     raw_end,
    input  logic [LW-1:0]     raw_base,
    input  logic [LW-1:0]     raw_mid,
    input  logic [DW-1:0]     raw_len1,
    input  logic [DW-1:0]     raw_len2,
    output logic              eff_three,
    output logic              eff_up,
    output logic [NSEG*LW-1:0] eff_segs,
    output logic [LW-1:0]     eff_end,
    output logic [LW-1:0]     eff_base,
    output logic [LW-1:0]     eff_mid,
    output logic [DW-1:0]     eff_len1,
    output logic [DW-1:0]     eff_len2
);

    logic              hd_three, hd_up;
    logic [NSEG*LW-1:0] hd_segs;
    logic [LW-1:0]     hd_end, hd_base, hd_mid;
    logic [DW-1:0]     hd_len1, hd_len2;

    // Snapshot every setting on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hd_three <= 1'b0;
            hd_up    <= 1'b0;
            hd_segs  <= '0;
            hd_end   <= '0;
            hd_base  <= '0;
            hd_mid   <= '0;
            hd_len1  <= '0;
            hd_len2  <= '0;
        end else if (accept) begin
            hd_three <= raw_three;
            hd_up    <= raw_up;
            hd_segs  <= raw_segs;
            hd_end   <= raw_end;
            hd_base  <= raw_base;
            hd_mid   <= raw_mid;
            hd_len1  <= raw_len1;
            hd_len2  <= raw_len2;
        end
    end

    // Bypass in the accepting cycle, snapshot afterwards
    always_comb begin
        eff_three = accept ? raw_three : hd_three;
        eff_up    = accept ? raw_up    : hd_up;
        eff_segs  = accept ? raw_segs  : hd_segs;
        eff_end   = accept ? raw_end   : hd_end;
        eff_base  = accept ? raw_base  : hd_base;
        eff_mid   = accept ? raw_mid   : hd_mid;
        eff_len1  = accept ? raw_len1  : hd_len1;
        eff_len2  = accept ? raw_len2  : hd_len2;
    end

    // Settings may not move while a profile plays, whatever the inputs do
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(hd_segs) && $stable(hd_end) && $stable(hd_base)
                                   && $stable(hd_mid) && $stable(hd_up) && $stable(hd_three)))
        else $error("settings changed during a profile"); // R10

endmodule

// File: rtl/gdrv_step_ctrl.sv
// Module: gdrv_step_ctrl
// Steps through the profile one segment per clock and registers the count
// and the selected bank. Free-form mode walks NSEG segment counts then the
// end level; three-phase mode plays base, middle, base using two durations.
// Assumes: NSEG >= 2; settings come from gdrv_cfg_hold (stable while busy).
module gdrv_step_ctrl
    import gdrv_pkg::*;
#(
    parameter int NSEG = 8,
    parameter int LW   = 6,
    parameter int DW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cf_three,
    input  logic              cf_up,
    input  logic [NSEG*LW-1:0] cf_segs,
    input  logic [LW-1:0]     cf_end,
    input  logic [LW-1:0]     cf_base,
    input  logic [LW-1:0]     cf_mid,
    input  logic [DW-1:0]     cf_len1,
    input  logic [DW-1:0]     cf_len2,
    output logic [LW-1:0]     lvl_q,
    output logic              up_q,
    output logic              busy,
    output logic              done
);

    localparam int SW = $clog2(NSEG);
    localparam int IW = $clog2(NSEG + 1);

    seq_state_t       st;
    logic [IW-1:0]    seg_idx;
    logic [DW-1:0]    left;
    logic [LW-1:0]    seg_arr [NSEG];
    logic [DW-1:0]    load1, load2;

    // Unpack the flat segment vector into one count per segment
    for (genvar g = 0; g < NSEG; g++) begin : g_unpack
        assign seg_arr[g] = cf_segs[g*LW +: LW];
    end

    // Remaining-cycle load values; a zero duration behaves as one cycle
    assign load1 = (cf_len1 == '0) ? '0 : cf_len1 - DW'(1);
    assign load2 = (cf_len2 == '0) ? '0 : cf_len2 - DW'(1);

    assign busy = (st != ST_IDLE);

    // Profile state machine with registered level, bank and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            seg_idx <= '0;
            left    <= '0;
            lvl_q   <= '0;
            up_q    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        up_q <= cf_up;
                        if (cf_three) begin
                            lvl_q <= cf_base;
                            left  <= load1;
                            st    <= ST_PH1;
                        end else begin
                            lvl_q   <= seg_arr[0];
                            seg_idx <= IW'(1);
                            st      <= ST_SEG;
                        end
                    end
                end
                ST_SEG: begin
                    if (seg_idx == IW'(NSEG)) begin
                        lvl_q <= cf_end;
                        done  <= 1'b1;
                        st    <= ST_IDLE;
                    end else begin
                        lvl_q   <= seg_arr[seg_idx[SW-1:0]];
                        seg_idx <= seg_idx + IW'(1);
                    end
                end
                ST_PH1: begin
                    if (left == '0) begin
                        lvl_q <= cf_mid;
                        left  <= load2;
                        st    <= ST_PH2;
                    end else begin
                        left <= left - DW'(1);
                    end
                end
                ST_PH2: begin
                    if (left == '0) begin
                        lvl_q <= cf_base;
                        done  <= 1'b1;
                        st    <= ST_IDLE;
                    end else begin
                        left <= left - DW'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Free-form segments advance by exactly one per cycle
    AST_SEG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEG && $past(st) == ST_SEG) |-> (seg_idx == $past(seg_idx) + IW'(1)))
        else $error("segment index skipped"); // R2

    // The middle level is held steady through the second phase
    AST_MID_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PH2 && $past(st) == ST_PH2) |-> $stable(lvl_q))
        else $error("middle level moved"); // R4

    // Bank choice cannot change once a profile is running
    AST_BANK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(up_q))
        else $error("bank changed mid-profile"); // R6

    // done is a single-cycle pulse
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one cycle"); // R8

    // busy only drops together with done
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done)
        else $error("busy fell without done"); // R7

endmodule

// File: rtl/gdrv_bank_steer.sv
// Module: gdrv_bank_steer
// Routes the registered count to the selected bank and forces the other
// bank to zero. Purely combinational from registers, so codes are glitch-free
// at the register boundary.
// Assumes: lvl and up come straight from flops.
module gdrv_bank_steer #(
    parameter int LW = 6
) (
    input  logic          up,
    input  logic [LW-1:0] lvl,
    output logic [LW-1:0] up_code,
    output logic [LW-1:0] down_code
);

    logic [LW-1:0] bank_code [2];

    // Bank 1 is the pull-up side, bank 0 the pull-down side
    for (genvar b = 0; b < 2; b++) begin : g_bank
        assign bank_code[b] = (up == (b == 1)) ? lvl : '0;
    end

    assign up_code   = bank_code[1];
    assign down_code = bank_code[0];

endmodule

// File: rtl/gdrv_profile_seq.sv
// Module: gdrv_profile_seq (top)
// Segmented gate-drive profile sequencer: on an accepted start it plays a
// free-form or three-phase drive-strength profile, one segment per clock,
// onto the pull-up or pull-down bank, then holds the final level.
// Assumes: one clock period per time segment; start is a synchronous pulse.
module gdrv_profile_seq #(
    parameter int NSEG = 8,
    parameter int LW   = 6,
    parameter int DW   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               three_phase,
    input  logic               drive_up,
    input  logic [NSEG*LW-1:0] seg_levels,
    input  logic [LW-1:0]      end_level,
    input  logic [LW-1:0]      base_level,
    input  logic [LW-1:0]      mid_level,
    input  logic [DW-1:0]      first_len,
    input  logic [DW-1:0]      second_len,
    output logic [LW-1:0]      up_code,
    output logic [LW-1:0]      down_code,
    output logic               busy,
    output logic               done
);

    logic               accept;
    logic               e_three, e_up;
    logic [NSEG*LW-1:0] e_segs;
    logic [LW-1:0]      e_end, e_base, e_mid;
    logic [DW-1:0]      e_len1, e_len2;
    logic [LW-1:0]      lvl_q;
    logic               up_q;

    // A start counts only when no profile is running
    assign accept = start && !busy;

    gdrv_cfg_hold #(.NSEG(NSEG), .LW(LW), .DW(DW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .busy      (busy),
        .raw_three (three_phase),
        .raw_up    (drive_up),
        .raw_segs  (seg_levels),
        .raw_end   (end_level),
        .raw_base  (base_level),
        .raw_mid   (mid_level),
        .raw_len1  (first_len),
        .raw_len2  (second_len),
        .eff_three (e_three),
        .eff_up    (e_up),
        .eff_segs  (e_segs),
        .eff_end   (e_end),
        .eff_base  (e_base),
        .eff_mid   (e_mid),
        .eff_len1  (e_len1),
        .eff_len2  (e_len2)
    );

    gdrv_step_ctrl #(.NSEG(NSEG), .LW(LW), .DW(DW)) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .cf_three (e_three),
        .cf_up    (e_up),
        .cf_segs  (e_segs),
        .cf_end   (e_end),
        .cf_base  (e_base),
        .cf_mid   (e_mid),
        .cf_len1  (e_len1),
        .cf_len2  (e_len2),
        .lvl_q    (lvl_q),
        .up_q     (up_q),
        .busy     (busy),
        .done     (done)
    );

    gdrv_bank_steer #(.LW(LW)) u_steer (
        .up        (up_q),
        .lvl       (lvl_q),
        .up_code   (up_code),
        .down_code (down_code)
    );

    // The idle bank never sees a count while the other bank is driven
    AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (up_code != '0) |-> (down_code == '0))
        else $error("both banks driven"); // R6

endmodule

// File: tb/gdrv_profile_seq_test.sv
// Directed bench for gdrv_profile_seq: one task per scenario.
module gdrv_profile_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        three_phase = 1'b0;
    logic        drive_up = 1'b0;
    logic [47:0] seg_levels = '0;
    logic [5:0]  end_level = '0;
    logic [5:0]  base_level = '0;
    logic [5:0]  mid_level = '0;
    logic [7:0]  first_len = '0;
    logic [7:0]  second_len = '0;
    logic [5:0]  up_code, down_code;
    logic        busy, done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    gdrv_profile_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .three_phase(three_phase),
        .drive_up(drive_up), .seg_levels(seg_levels), .end_level(end_level),
        .base_level(base_level), .mid_level(mid_level), .first_len(first_len),
        .second_len(second_len), .up_code(up_code), .down_code(down_code),
        .busy(busy), .done(done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Check the outputs of the current cycle against an expected count/bank/flags
    task automatic expect_cyc(input string req, input bit up, input int lvl,
                              input bit bsy, input bit dn);
        chk(req, "up_code",   int'(up_code),   up ? lvl : 0);
        chk(req, "down_code", int'(down_code), up ? 0 : lvl);
        chk(req, "busy",      int'(busy),      int'(bsy));
        chk(req, "done",      int'(done),      int'(dn));
    endtask

    // Pulse start for one edge; returns in the 1st cycle after the start edge
    task automatic fire();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    function automatic int seg_of(input logic [47:0] v, input int j);
        return int'(v[j*6 +: 6]);
    endfunction

    // R1: reset state
    task automatic t_reset();
        @(negedge clk);
        expect_cyc("R1", 1'b1, 0, 1'b0, 1'b0);
    endtask

    // R2 R3 R6 R7 R8: free-form profile on the pull-up bank
    task automatic t_free_up();
        logic [47:0] v = {6'd40, 6'd5, 6'd32, 6'd31, 6'd62, 6'd1, 6'd63, 6'd0};
        three_phase = 1'b0; drive_up = 1'b1; seg_levels = v; end_level = 6'd17;
        fire();
        for (int j = 0; j < 8; j++) begin
            expect_cyc("R2", 1'b1, seg_of(v, j), 1'b1, 1'b0);
            @(negedge clk);
        end
        expect_cyc("R8", 1'b1, 17, 1'b0, 1'b1);
        @(negedge clk);
        expect_cyc("R3", 1'b1, 17, 1'b0, 1'b0);
        @(negedge clk);
        expect_cyc("R7", 1'b1, 17, 1'b0, 1'b0);
    endtask

    // Three-phase profile; called in the 1st cycle after the start edge
    task automatic run_three(input string req, input bit up, input int m, input int i,
                             input int l1, input int l2);
        int e1 = (l1 == 0) ? 1 : l1;
        int e2 = (l2 == 0) ? 1 : l2;
        for (int c = 0; c < e1; c++) begin
            expect_cyc(req, up, m, 1'b1, 1'b0);
            @(negedge clk);
        end
        for (int c = 0; c < e2; c++) begin
            expect_cyc(req, up, i, 1'b1, 1'b0);
            @(negedge clk);
        end
        expect_cyc(req, up, m, 1'b0, 1'b1);
        @(negedge clk);
        expect_cyc(req, up, m, 1'b0, 1'b0);
    endtask

    // R4 R6: short asymmetric three-phase on the pull-down bank
    task automatic t_three_down();
        three_phase = 1'b1; drive_up = 1'b0;
        base_level = 6'd63; mid_level = 6'd10; first_len = 8'd1; second_len = 8'd2;
        fire();
        run_three("R4", 1'b0, 63, 10, 1, 2);
    endtask

    // R4: 4+4 cycle profile with an intermediate level of 0 on pull-up
    task automatic t_three_even();
        three_phase = 1'b1; drive_up = 1'b1;
        base_level = 6'd31; mid_level = 6'd0; first_len = 8'd4; second_len = 8'd4;
        fire();
        run_three("R4", 1'b1, 31, 0, 4, 4);
    endtask

    // R5: zero durations behave as one cycle each
    task automatic t_zero_len();
        three_phase = 1'b1; drive_up = 1'b0;
        base_level = 6'd32; mid_level = 6'd7; first_len = 8'd0; second_len = 8'd0;
        fire();
        run_three("R5", 1'b0, 32, 7, 0, 0);
    endtask

    // R9 R10: mid-profile start and setting changes are ignored
    task automatic t_ignore();
        logic [47:0] v = {6'd8, 6'd7, 6'd6, 6'd5, 6'd4, 6'd3, 6'd2, 6'd1};
        three_phase = 1'b0; drive_up = 1'b1; seg_levels = v; end_level = 6'd44;
        fire();
        for (int j = 0; j < 8; j++) begin
            expect_cyc((j < 3) ? "R2" : "R9", 1'b1, seg_of(v, j), 1'b1, 1'b0);
            if (j == 2) begin
                start = 1'b1; three_phase = 1'b1; drive_up = 1'b0;
                seg_levels = '1; end_level = 6'd3; base_level = 6'd50; first_len = 8'd1;
            end
            if (j == 3) start = 1'b0;
            @(negedge clk);
        end
        expect_cyc("R10", 1'b1, 44, 1'b0, 1'b1);
    endtask

    // R11: a start on the done cycle launches the next profile at once
    task automatic t_back2back();
        logic [47:0] v = {6'd63, 6'd0, 6'd63, 6'd0, 6'd63, 6'd0, 6'd63, 6'd0};
        three_phase = 1'b0; drive_up = 1'b0; seg_levels = v; end_level = 6'd9;
        fire();
        for (int j = 0; j < 8; j++) begin
            expect_cyc("R2", 1'b0, seg_of(v, j), 1'b1, 1'b0);
            @(negedge clk);
        end
        expect_cyc("R3", 1'b0, 9, 1'b0, 1'b1);
        start = 1'b1; three_phase = 1'b1; drive_up = 1'b1;
        base_level = 6'd20; mid_level = 6'd40; first_len = 8'd2; second_len = 8'd1;
        @(negedge clk) start = 1'b0;
        run_three("R11", 1'b1, 20, 40, 2, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_free_up();
        t_three_down();
        t_three_even();
        t_zero_len();
        t_ignore();
        t_back2back();
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule